// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flow-Control Output

This block takes one asynchronous serial line and turns each incoming character into a parallel byte held in a receive buffer. The character is a low start bit, eight data bits with the least significant bit first, and a single high stop bit. There is no parity. The receiver oversamples the line 16 times per bit. Its oversampling tick comes from a baud generator that divides either the system clock or the system clock divided by eight by the reload value plus one.

Software, or a neighbouring controller, sees the byte on a parallel output. A "buffer full" flag reports that a byte is waiting. A separate interrupt flag stays set until it is acknowledged. The block also drives a request-to-send output for hardware flow control. That output goes high (not ready) as soon as a frame starts. It stays high until the buffer has been read. The block also reports a stop bit that was sampled low and a byte that arrived before the previous one was read.

Top module: `uart_rx_rts`

## Requirements
- R1: The oversampling tick period is (reload_i+1)×S system clocks, where S is 1 when src_div8_i is 0 and 8 when it is 1. A bit lasts 16 ticks. The generator restarts its count at the clock edge that detects a start edge.
- R2: rxd_i passes through two flops before edge detection. While enabled and idle, a high-to-low transition starts a frame. The line is checked again on the 8th tick. If it is high there, the frame is dropped and no byte is stored.
- R3: Data bits are sampled every 16 ticks after the start check and are assembled least significant bit first: the first data bit lands in rx_data_o[0] and the eighth in rx_data_o[7].
- R4: The stop bit is sampled 16 ticks after the eighth data bit. On that clock edge the assembled byte is written to rx_data_o and rx_full_o is set. This edge comes 152 ticks after the edge that detected the start.
- R5: rx_data_o changes only when a byte completes.
- R6: irq_o is set when a byte completes and is cleared by a one-cycle irq_ack_i pulse. A buffer read leaves irq_o unchanged.
- R7: rts_o is high from the edge that detects a start until the stored byte has been read. It is low when no frame is in progress and the buffer is empty.
- R8: A buf_rd_i pulse clears rx_full_o, frame_err_o and overrun_o. A pulse while the buffer is empty changes nothing.
- R9: While rx_en_i is 0, start edges are ignored, and a frame already in progress is abandoned without storing a byte.
- R10: A stop bit sampled low sets frame_err_o. The byte is still stored and rx_full_o is still set.
- R11: A byte that completes while rx_full_o is 1 sets overrun_o and replaces the buffer contents.
- R12: After reset, rx_data_o is 0x00, and rx_full_o, irq_o, rts_o, frame_err_o and overrun_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd_i | input | 1 | Serial receive line, idles high |
| reload_i | input | RELOAD_W | Baud divider reload value n (divide by n+1) |
| src_div8_i | input | 1 | Count source select: 0 = system clock, 1 = system clock / 8 |
| rx_en_i | input | 1 | Receive enable |
| buf_rd_i | input | 1 | One-cycle strobe: the buffer has been read |
| irq_ack_i | input | 1 | One-cycle strobe: clear the interrupt flag |
| rx_data_o | output | 8 | Receive buffer contents |
| rx_full_o | output | 1 | A received byte is waiting |
| irq_o | output | 1 | Receive interrupt request |
| rts_o | output | 1 | Flow control: 1 = not ready, 0 = ready |
| frame_err_o | output | 1 | The stored byte had a low stop bit |
| overrun_o | output | 1 | A byte overwrote an unread byte |

## Verification
A behavioural model in the bench predicts every output on every clock, so a divider that is off by one source clock shifts the sample points and the completion edge and is caught at once. Several corner cases are targeted:
- A short low glitch: a receiver that skips the start recheck would store a garbage byte.
- A stop bit driven low: the receiver must flag it without dropping the byte.
- A second byte arriving unread: a design that ignored it, or failed to flag it, would leave the wrong data or no overrun.
- The enable dropping partway through a frame: a sloppy design would finish the frame anyway.

RTS is tracked through frames, reads, false starts and disables, so it is checked throughout.

// File: rtl/uart_rx_pkg.sv
// Package: shared types of the serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_rx_pkg;

    // Receive sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rx_baud_gen.sv
// Module: rx_baud_gen
// Produces a one-cycle oversampling tick every (reload+1)*S clocks, where
// S is 1 or PRE_DIV as chosen by div_sel_i.
// Assumes: PRE_DIV is a power of two; restart_i reloads both counters so the
// first tick comes one full period after restart.
module rx_baud_gen #(
    parameter int RELOAD_W = 8,
    parameter int PRE_DIV  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart_i,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic                div_sel_i,
    output logic                tick_o
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic [PRE_W-1:0]    pre_cnt;
    logic [RELOAD_W-1:0] rl_cnt;
    logic                pre_tick;

    // Count-source enable: every clock, or once per PRE_DIV clocks.
    always_comb begin
        pre_tick = div_sel_i ? (pre_cnt == PRE_W'(PRE_DIV - 1)) : 1'b1;
        tick_o   = pre_tick && (rl_cnt == '0);
    end

    // Prescaler and reload down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            rl_cnt  <= '0;
        end else if (restart_i) begin
            pre_cnt <= '0;
            rl_cnt  <= reload_i;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
            if (pre_tick) begin
                rl_cnt <= (rl_cnt == '0) ? reload_i : rl_cnt - RELOAD_W'(1);
            end
        end
    end
endmodule

// File: rtl/rx_sync_edge.sv
// Module: rx_sync_edge
// Brings the serial line into the clock domain with two flops and flags a
// high-to-low transition of the synchronised line.
// Assumes: the line idles high; reset values are high so no false edge.
module rx_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    logic meta_q, sync_q, prev_q;

    // Two-stage synchroniser followed by a history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge flag and synchronised level.
    always_comb begin
        line_o = sync_q;
        fall_o = prev_q && !sync_q;
    end
endmodule

// File: rtl/rx_frame_fsm.sv
// Module: rx_frame_fsm
// Sequences one frame: start recheck at mid-bit, DATA_W data bits taken
// least significant first, then the stop bit. It pulses done_o on the stop
// sample, together with the sampled stop level.
// Assumes: OSR is a power of two so the tick counter wraps on its own.
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rx_i,
    input  logic              fall_i,
    input  logic              tick_i,
    output logic              restart_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              stop_bit_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int MID   = OSR / 2 - 1;
    localparam int LAST  = OSR - 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state;
    logic [CNT_W-1:0]  tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              mid_hit, end_hit;

    // Decode of sample points and frame events.
    always_comb begin
        mid_hit    = tick_i && (tick_cnt == CNT_W'(MID));
        end_hit    = tick_i && (tick_cnt == CNT_W'(LAST));
        restart_o  = en_i && (state == ST_IDLE) && fall_i;
        busy_o     = (state != ST_IDLE);
        done_o     = en_i && (state == ST_STOP) && end_hit;
        stop_bit_o = rx_i;
        data_o     = shreg;
    end

    // Frame sequencer, tick counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
        end else if (!en_i) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fall_i) begin
                        state    <= ST_START;
                        tick_cnt <= '0;
                    end
                end
                ST_START: begin
                    if (mid_hit) begin
                        if (rx_i) begin
                            state <= ST_IDLE;
                        end else begin
                            state    <= ST_DATA;
                            tick_cnt <= '0;
                            bit_idx  <= '0;
                        end
                    end else if (tick_i) begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (tick_i) begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                    end
                    if (end_hit) begin
                        shreg   <= {rx_i, shreg[DATA_W-1:1]};
                        bit_idx <= bit_idx + IDX_W'(1);
                        if (bit_idx == IDX_W'(DATA_W - 1)) begin
                            state <= ST_STOP;
                        end
                    end
                end
                default: begin
                    if (tick_i) begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                    end
                    if (end_hit) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_buffer_flags.sv
// Module: rx_buffer_flags
// Holds the receive buffer and its full, interrupt, framing and overrun
// flags.
// Assumes: a completion in the same cycle as a read or an acknowledge wins.
module rx_buffer_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              stop_bit_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rd_i,
    input  logic              ack_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              irq_o,
    output logic              ferr_o,
    output logic              ovr_o
);
    // Buffer load on completion; clears on read and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            full_o <= 1'b0;
            irq_o  <= 1'b0;
            ferr_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else if (done_i) begin
            data_o <= data_i;
            full_o <= 1'b1;
            irq_o  <= 1'b1;
            ferr_o <= !stop_bit_i;
            ovr_o  <= ovr_o || full_o;
        end else begin
            if (rd_i) begin
                full_o <= 1'b0;
                ferr_o <= 1'b0;
                ovr_o  <= 1'b0;
            end
            if (ack_i) begin
                irq_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_rx_rts.sv
// Module: uart_rx_rts (top)
// Asynchronous receiver: synchroniser, baud generator, frame sequencer and
// receive buffer. rts_o signals not-ready while a frame is in progress or an
// unread byte is held.
// Assumes: 8N1 frames; all control inputs are synchronous to clk.
module uart_rx_rts #(
    parameter int RELOAD_W = 8,
    parameter int PRE_DIV  = 8,
    parameter int OSR      = 16,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxd_i,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic                src_div8_i,
    input  logic                rx_en_i,
    input  logic                buf_rd_i,
    input  logic                irq_ack_i,
    output logic [DATA_W-1:0]   rx_data_o,
    output logic                rx_full_o,
    output logic                irq_o,
    output logic                rts_o,
    output logic                frame_err_o,
    output logic                overrun_o
);
    logic              line_s, fall_s, tick, restart;
    logic              busy, done, stop_bit;
    logic [DATA_W-1:0] shift_data;

    rx_sync_edge u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rxd_i),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    rx_baud_gen #(.RELOAD_W(RELOAD_W), .PRE_DIV(PRE_DIV)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .reload_i  (reload_i),
        .div_sel_i (src_div8_i),
        .tick_o    (tick)
    );

    rx_frame_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (rx_en_i),
        .rx_i       (line_s),
        .fall_i     (fall_s),
        .tick_i     (tick),
        .restart_o  (restart),
        .busy_o     (busy),
        .done_o     (done),
        .stop_bit_o (stop_bit),
        .data_o     (shift_data)
    );

    rx_buffer_flags #(.DATA_W(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .stop_bit_i (stop_bit),
        .data_i     (shift_data),
        .rd_i       (buf_rd_i),
        .ack_i      (irq_ack_i),
        .data_o     (rx_data_o),
        .full_o     (rx_full_o),
        .irq_o      (irq_o),
        .ferr_o     (frame_err_o),
        .ovr_o      (overrun_o)
    );

    // Flow control: not ready while receiving or holding an unread byte.
    always_comb rts_o = busy || rx_full_o;
endmodule

// File: rtl/uart_rx_rts_chk.sv
// Module: uart_rx_rts_chk
// Temporal checks on the receiver, bound into every uart_rx_rts instance.
// Assumes: done and busy are the sequencer's completion pulse and
// frame-in-progress level.
module uart_rx_rts_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en_i,
    input logic              buf_rd_i,
    input logic              irq_ack_i,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_full_o,
    input logic              irq_o,
    input logic              rts_o,
    input logic              frame_err_o,
    input logic              overrun_o,
    input logic              done,
    input logic              busy
);
    p_done_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full_o);

    p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rx_data_o));

    p_done_raises_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_o);

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !done) |=> !irq_o);

    p_rts_covers_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_o |-> rts_o);

    p_read_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_i && !done) |=> (!rx_full_o && !overrun_o && !frame_err_o));

    p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !busy);

    p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full_o) |=> overrun_o);
endmodule

bind uart_rx_rts uart_rx_rts_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en_i     (rx_en_i),
    .buf_rd_i    (buf_rd_i),
    .irq_ack_i   (irq_ack_i),
    .rx_data_o   (rx_data_o),
    .rx_full_o   (rx_full_o),
    .irq_o       (irq_o),
    .rts_o       (rts_o),
    .frame_err_o (frame_err_o),
    .overrun_o   (overrun_o),
    .done        (done),
    .busy        (busy)
);

// File: tb/tb_uart_rx_rts.sv
// Bench for uart_rx_rts: a behavioural model predicts every output each clock.
module tb_uart_rx_rts;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] reload = 8'd3;
    logic       div8 = 1'b0;
    logic       rx_en = 1'b1;
    logic       buf_rd = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, irq, rts, ferr, ovr;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    uart_rx_rts dut (
        .clk (clk), .rst_n (rst_n), .rxd_i (rxd), .reload_i (reload),
        .src_div8_i (div8), .rx_en_i (rx_en), .buf_rd_i (buf_rd),
        .irq_ack_i (irq_ack), .rx_data_o (rx_data), .rx_full_o (rx_full),
        .irq_o (irq), .rts_o (rts), .frame_err_o (ferr), .overrun_o (ovr)
    );

    always #5 clk = ~clk;

    // Behavioural model state.
    logic       m_busy, m_full, m_irq, m_ferr, m_ovr, m_done, m_stop;
    logic [7:0] m_data, m_shift;
    logic       s_now, s_prev;
    logic       line_q[$];
    int         t0, p, k, j;

    function automatic int cur_period();
        return (int'(reload) + 1) * (div8 ? 8 : 1);
    endfunction

    // Reference model: line seen two edges late, frame timed in ticks.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_full = 0; m_irq = 0; m_ferr = 0; m_ovr = 0;
            m_data = 8'h00; m_shift = 8'h00; t0 = 0; p = 1;
            line_q = '{1'b1, 1'b1, 1'b1, 1'b1};
        end else begin
            cyc++;
            line_q.push_back(rxd);
            if (line_q.size() > 8) void'(line_q.pop_front());
            s_now  = line_q[line_q.size() - 3];
            s_prev = line_q[line_q.size() - 4];
            m_done = 0;
            m_stop = 1;
            if (m_busy) begin
                k = cyc - t0;
                if (!rx_en) begin
                    m_busy = 0;
                end else if (k == 8 * p) begin
                    if (s_now) m_busy = 0;
                end else if (k > 8 * p && ((k - 8 * p) % (16 * p)) == 0) begin
                    j = (k - 8 * p) / (16 * p);
                    if (j <= 8) m_shift[j-1] = s_now;
                    else if (j == 9) begin
                        m_done = 1; m_stop = s_now; m_busy = 0;
                    end
                end
            end else if (rx_en && s_prev && !s_now) begin
                m_busy = 1; t0 = cyc; p = cur_period();
            end
            if (m_done) begin
                m_data = m_shift;
                m_ovr  = m_ovr | m_full;
                m_full = 1; m_irq = 1; m_ferr = !m_stop;
            end else begin
                if (buf_rd) begin m_full = 0; m_ferr = 0; m_ovr = 0; end
                if (irq_ack) m_irq = 0;
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h",
                     tag, what, cyc, act, exp);
        end
    endtask

    // Every-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R4", "rx_data", rx_data, m_data);
            check("R4", "rx_full", {7'd0, rx_full}, {7'd0, m_full});
            check("R6", "irq", {7'd0, irq}, {7'd0, m_irq});
            check("R7", "rts", {7'd0, rts}, {7'd0, m_busy | m_full});
            check("R10", "frame_err", {7'd0, ferr}, {7'd0, m_ferr});
            check("R11", "overrun", {7'd0, ovr}, {7'd0, m_ovr});
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop);
        int bt;
        bt = 16 * cur_period();
        rxd = 1'b0; wait_clks(bt);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i]; wait_clks(bt);
        end
        rxd = stop; wait_clks(bt);
        rxd = 1'b1; wait_clks(bt);
    endtask

    task automatic pulse_read();
        buf_rd = 1'b1; wait_clks(1); buf_rd = 1'b0; wait_clks(2);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; wait_clks(1); irq_ack = 1'b0; wait_clks(2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        // R12: reset state
        check("R12", "reset data", rx_data, 8'h00);
        check("R12", "reset flags", {3'd0, rx_full, irq, rts, ferr, ovr}, 8'h00);

        // R3 R4: normal byte, R1 with system clock source, reload 3
        send_frame(8'hA5, 1'b1);
        check("R3", "byte A5", rx_data, 8'hA5);
        check("R4", "full after A5", {7'd0, rx_full}, 8'd1);
        check("R7", "rts held for unread byte", {7'd0, rts}, 8'd1);

        // R6: acknowledge clears irq only; R5 data held
        pulse_ack();
        check("R6", "irq after ack", {7'd0, irq}, 8'd0);
        check("R5", "data held after ack", rx_data, 8'hA5);

        // R8: read empties, rts released; second read harmless
        pulse_read();
        check("R8", "full after read", {7'd0, rx_full}, 8'd0);
        check("R7", "rts after read", {7'd0, rts}, 8'd0);
        pulse_read();
        check("R8", "empty read", {3'd0, rx_full, irq, rts, ferr, ovr}, 8'h00);
        check("R5", "data held after reads", rx_data, 8'hA5);

        // R10: stop bit low
        send_frame(8'h3C, 1'b0);
        check("R10", "frame error set", {7'd0, ferr}, 8'd1);
        check("R10", "byte still stored", rx_data, 8'h3C);
        pulse_read();
        pulse_ack();

        // R11: overrun
        send_frame(8'h81, 1'b1);
        send_frame(8'h7E, 1'b1);
        check("R11", "overrun set", {7'd0, ovr}, 8'd1);
        check("R11", "buffer replaced", rx_data, 8'h7E);
        pulse_read();
        check("R8", "overrun cleared by read", {7'd0, ovr}, 8'd0);
        pulse_ack();

        // R2: short low glitch is rejected at the mid-bit check
        rxd = 1'b0; wait_clks(12); rxd = 1'b1; wait_clks(80);
        check("R2", "glitch stores nothing", {7'd0, rx_full}, 8'd0);
        check("R2", "rts back low after glitch", {7'd0, rts}, 8'd0);

        // R9: disabled receiver ignores a whole frame
        rx_en = 1'b0;
        send_frame(8'h5A, 1'b1);
        check("R9", "disabled no byte", {7'd0, rx_full}, 8'd0);
        check("R9", "disabled rts low", {7'd0, rts}, 8'd0);
        rx_en = 1'b1;
        wait_clks(4);

        // R9: disable during a frame abandons it
        fork
            send_frame(8'hC3, 1'b1);
            begin wait_clks(200); rx_en = 1'b0; end
        join
        rx_en = 1'b1;
        wait_clks(4);
        check("R9", "abandoned frame", {7'd0, rx_full}, 8'd0);
        check("R5", "data untouched", rx_data, 8'h7E);

        // R1: divided-by-8 source, reload 1
        div8 = 1'b1; reload = 8'd1;
        wait_clks(4);
        send_frame(8'h00, 1'b1);
        check("R1", "byte 00 via div8", rx_data, 8'h00);
        check("R1", "full via div8", {7'd0, rx_full}, 8'd1);
        pulse_read();
        send_frame(8'hFF, 1'b1);
        check("R1", "byte FF via div8", rx_data, 8'hFF);
        pulse_read();
        pulse_ack();

        // R1: fastest rate, reload 0 on system clock
        div8 = 1'b0; reload = 8'd0;
        wait_clks(4);
        send_frame(8'h96, 1'b1);
        check("R1", "byte 96 at reload 0", rx_data, 8'h96);
        check("R6", "irq on completion", {7'd0, irq}, 8'd1);
        pulse_read();
        check("R6", "read keeps irq", {7'd0, irq}, 8'd1);
        wait_clks(4);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule